// File: doc/BRIEF.md
# Match Address Tree Encoder

This block sits behind a multi-signature string matcher. The matcher finishes scanning a block of input and loads a buffer with one bit per signature. Each bit marks a signature that matched. Control logic then raises a start strobe. The encoder reports whether any match is present. It then returns the binary index of every set bit, one index per output transfer, from lowest to highest.

The index of a set bit is found by descending a binary OR tree that spans the buffer. At each level the lower-index child is taken when its subtree holds a set bit. The direction taken at each level gives one bit of the address. The whole descent is combinational, so an address is ready in every cycle. Each accepted address clears its bit in the buffer, and the tree updates on the next cycle. Draining M matches therefore takes M cycles, whatever the number of signatures. A one-cycle done pulse marks the end of the drain.

Top module: `sig_addr_encoder`

## Requirements
- R1: After reset, anyMatch, addrValid and done are 0 and the match buffer is empty, so a start with no load produces no address.
- R2: loadEn captures matchIn into the buffer only in a cycle where the encoder is idle and start is low. A loadEn during a drain, or in the same cycle as start, leaves the buffer unchanged.
- R3: A start while idle with a non-empty buffer raises anyMatch and addrValid in the next cycle.
- R4: addrOut is the binary index of the lowest-numbered set bit still in the buffer. Bit i of matchIn yields address i. Each set bit is reported exactly once, in ascending order.
- R5: While addrValid is 1 and addrReady is 0, addrValid stays 1 and addrOut holds its value.
- R6: A cycle with addrValid and addrReady both 1 clears the reported bit. The next address is presented in the following cycle, so with addrReady held at 1 the M addresses appear in M consecutive cycles.
- R7: done pulses for exactly one cycle, in the cycle after the final address is accepted. anyMatch and addrValid are 0 in that same cycle.
- R8: A start with an empty buffer emits no address, leaves anyMatch at 0, and pulses done in the next cycle.
- R9: The address is $clog2(NUM_SIGS) bits wide. The highest signature (index NUM_SIGS-1) and a fully set buffer drain correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| loadEn | input | 1 | Capture matchIn into the match buffer (idle only) |
| matchIn | input | NUM_SIGS | Per-signature match bits from the matcher |
| start | input | 1 | Begin draining the buffer (scan of the block finished) |
| anyMatch | output | 1 | At least one match is present and draining |
| addrOut | output | $clog2(NUM_SIGS) | Index of the signature being reported |
| addrValid | output | 1 | addrOut holds a valid address |
| addrReady | input | 1 | Consumer accepts addrOut this cycle |
| done | output | 1 | One-cycle pulse: the drain is finished |

## Verification
The first address and anyMatch are due one cycle after start is sampled. Each following address is due one cycle after the transfer that accepted the previous one. done is due one cycle after the last transfer, or one cycle after a start on an empty buffer. The bench drives inputs on the falling edge and reads outputs on the next falling edge, so every check falls exactly one register stage after its stimulus. With addrReady held high it also counts the falling edges from start to done and expects M+1.

// File: rtl/sig_addr_pkg.sv
package sig_addr_pkg;

  typedef struct packed {
    logic load;
    logic pop;
  } encStrobes_t;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_DRAIN = 1'b1
  } encState_t;

endpackage

// File: rtl/sig_addr_walk.sv
module sig_addr_walk #(
  parameter int NUM_SIGS = 16,
  parameter int ADDR_W   = $clog2(NUM_SIGS)
) (
  input  logic [NUM_SIGS-1:0] bits,
  output logic [ADDR_W-1:0]   leafAddr,
  output logic                anySet
);

  localparam int LEAVES = 1 << ADDR_W;

  // heap-ordered OR tree: node 1 is the root, leaves at LEAVES..2*LEAVES-1
  logic [2*LEAVES-1:1] node;

  generate
    if (LEAVES > NUM_SIGS) begin : g_pad
      assign node[2*LEAVES-1:LEAVES] = {{(LEAVES-NUM_SIGS){1'b0}}, bits};
    end else begin : g_exact
      assign node[2*LEAVES-1:LEAVES] = bits;
    end
    for (genvar n = 1; n < LEAVES; n++) begin : g_or
      assign node[n] = node[2*n] | node[2*n+1];
    end
  endgenerate

  assign anySet = node[1];

  // descend from the root; each level contributes one address bit
  always_comb begin
    int idx;
    idx      = 1;
    leafAddr = '0;
    for (int lvl = 0; lvl < ADDR_W; lvl++) begin
      if (node[2*idx]) begin
        idx = 2 * idx;
        leafAddr[ADDR_W-1-lvl] = 1'b0;
      end else begin
        idx = 2 * idx + 1;
        leafAddr[ADDR_W-1-lvl] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/sig_addr_datapath.sv
module sig_addr_datapath
  import sig_addr_pkg::*;
#(
  parameter int NUM_SIGS = 16,
  parameter int ADDR_W   = $clog2(NUM_SIGS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  encStrobes_t         strobes,
  input  logic [NUM_SIGS-1:0] matchIn,
  output logic [ADDR_W-1:0]   addrOut,
  output logic                bufEmpty,
  output logic                restEmpty
);

  logic [NUM_SIGS-1:0] matchBuf;
  logic [NUM_SIGS-1:0] clearMask;
  logic [NUM_SIGS-1:0] lowerMask;
  logic                anySet;

  sig_addr_walk #(
    .NUM_SIGS(NUM_SIGS),
    .ADDR_W  (ADDR_W)
  ) u_walk (
    .bits    (matchBuf),
    .leafAddr(addrOut),
    .anySet  (anySet)
  );

  assign clearMask = NUM_SIGS'(1) << addrOut;
  assign lowerMask = clearMask - NUM_SIGS'(1);
  assign bufEmpty  = ~anySet;
  assign restEmpty = ~|(matchBuf & ~clearMask);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      matchBuf <= '0;
    end else if (strobes.load) begin
      matchBuf <= matchIn;
    end else if (strobes.pop) begin
      matchBuf <= matchBuf & ~clearMask;
    end
  end

  AST_LOWEST_SET: assert property (@(posedge clk) disable iff (!rstN)
    !bufEmpty |-> (matchBuf[addrOut] && ((matchBuf & lowerMask) == '0))); // R4

  AST_BUF_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.load && !strobes.pop) |=> $stable(matchBuf)); // R2

  AST_POP_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.pop |=> !matchBuf[$past(addrOut)]); // R6

  AST_ASCENDING: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.pop && !restEmpty) |=> (addrOut > $past(addrOut))); // R4

endmodule

// File: rtl/sig_addr_ctrl.sv
module sig_addr_ctrl
  import sig_addr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        loadEn,
  input  logic        start,
  input  logic        addrReady,
  input  logic        bufEmpty,
  input  logic        restEmpty,
  output encStrobes_t strobes,
  output logic        addrValid,
  output logic        anyMatch,
  output logic        done
);

  encState_t state;
  encState_t stateNext;
  logic      isIdle;
  logic      lastPop;
  logic      emptyStart;

  assign isIdle      = (state == ST_IDLE);
  assign addrValid   = (state == ST_DRAIN);
  assign anyMatch    = (state == ST_DRAIN);
  assign strobes.load = isIdle && loadEn && !start;
  assign strobes.pop  = addrValid && addrReady;
  assign lastPop     = strobes.pop && restEmpty;
  assign emptyStart  = isIdle && start && bufEmpty;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (start && !bufEmpty) stateNext = ST_DRAIN;
      ST_DRAIN: if (lastPop)            stateNext = ST_IDLE;
      default:                          stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= lastPop || emptyStart;
    end
  end

  AST_START_DRAINS: assert property (@(posedge clk) disable iff (!rstN)
    (isIdle && start && !bufEmpty) |=> (addrValid && anyMatch)); // R3

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && !addrReady) |=> addrValid); // R5

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!anyMatch && !addrValid)); // R7

  AST_EMPTY_START: assert property (@(posedge clk) disable iff (!rstN)
    emptyStart |=> (done && !anyMatch)); // R8

endmodule

// File: rtl/sig_addr_encoder.sv
module sig_addr_encoder
  import sig_addr_pkg::*;
#(
  parameter int NUM_SIGS = 16,
  parameter int ADDR_W   = $clog2(NUM_SIGS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                loadEn,
  input  logic [NUM_SIGS-1:0] matchIn,
  input  logic                start,
  output logic                anyMatch,
  output logic [ADDR_W-1:0]   addrOut,
  output logic                addrValid,
  input  logic                addrReady,
  output logic                done
);

  encStrobes_t strobes;
  logic        bufEmpty;
  logic        restEmpty;

  sig_addr_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .loadEn   (loadEn),
    .start    (start),
    .addrReady(addrReady),
    .bufEmpty (bufEmpty),
    .restEmpty(restEmpty),
    .strobes  (strobes),
    .addrValid(addrValid),
    .anyMatch (anyMatch),
    .done     (done)
  );

  sig_addr_datapath #(
    .NUM_SIGS(NUM_SIGS),
    .ADDR_W  (ADDR_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .matchIn  (matchIn),
    .addrOut  (addrOut),
    .bufEmpty (bufEmpty),
    .restEmpty(restEmpty)
  );

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && !addrReady) |=> $stable(addrOut)); // R5

endmodule

// File: tb/sig_addr_encoder_tb.sv
module sig_addr_encoder_tb;

  localparam int NS = 16;
  localparam int AW = $clog2(NS);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          loadEn = 1'b0;
  logic [NS-1:0] matchIn = '0;
  logic          start = 1'b0;
  logic          addrReady = 1'b0;
  logic          anyMatch;
  logic [AW-1:0] addrOut;
  logic          addrValid;
  logic          done;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  sig_addr_encoder #(.NUM_SIGS(NS)) u_dut (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .matchIn(matchIn),
    .start(start), .anyMatch(anyMatch), .addrOut(addrOut),
    .addrValid(addrValid), .addrReady(addrReady), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic loadBuf(input logic [NS-1:0] v);
    @(negedge clk);
    loadEn = 1'b1; matchIn = v;
    @(negedge clk);
    loadEn = 1'b0; matchIn = '0;
  endtask

  // start, drain expecting the bits of expV, optionally stalling on every address
  task automatic drain(input logic [NS-1:0] expV, input bit stall, input bit disturb);
    int cyc;
    bit first;
    start = 1'b1;
    addrReady = !stall;
    cyc = 0;
    first = 1'b1;
    for (int i = 0; i < NS; i++) begin
      if (expV[i]) begin
        @(negedge clk); cyc++;
        start = 1'b0; loadEn = 1'b0;
        if (first) chk(anyMatch === 1'b1, "R3 anyMatch", int'(anyMatch), 1);
        chk(addrValid === 1'b1, "R4 valid", int'(addrValid), 1);
        chk(addrOut === AW'(i), "R4 addr", int'(addrOut), i);
        if (first && disturb) begin
          start = 1'b1; loadEn = 1'b1; matchIn = '1; // R2: ignored while draining
        end
        first = 1'b0;
        if (stall) begin
          addrReady = 1'b0;
          @(negedge clk); cyc++;
          start = 1'b0; loadEn = 1'b0; matchIn = '0;
          chk(addrValid === 1'b1, "R5 valid held", int'(addrValid), 1);
          chk(addrOut === AW'(i), "R5 addr held", int'(addrOut), i);
          addrReady = 1'b1;
        end
      end
    end
    @(negedge clk); cyc++;
    start = 1'b0; loadEn = 1'b0; matchIn = '0;
    chk(done === 1'b1, (expV == '0) ? "R8 done" : "R7 done", int'(done), 1);
    chk(anyMatch === 1'b0 && addrValid === 1'b0, (expV == '0) ? "R8 quiet" : "R7 quiet",
        int'({anyMatch, addrValid}), 0);
    if (!stall) chk(cyc == $countones(expV) + 1, "R6 cycles", cyc, $countones(expV) + 1);
    addrReady = 1'b0;
    @(negedge clk);
    chk(done === 1'b0, "R7 single pulse", int'(done), 0);
  endtask

  task automatic testReset();
    @(negedge clk);
    chk(anyMatch === 1'b0 && addrValid === 1'b0 && done === 1'b0, "R1 outputs",
        int'({anyMatch, addrValid, done}), 0);
    drain('0, 1'b0, 1'b0); // R1: buffer starts empty
  endtask

  task automatic testBasic();
    loadBuf(16'h8421); drain(16'h8421, 1'b0, 1'b0);   // R4 R6
    loadBuf(16'h0018); drain(16'h0018, 1'b0, 1'b0);   // R6 adjacent
  endtask

  task automatic testStall();
    loadBuf(16'h0A05); drain(16'h0A05, 1'b1, 1'b0);   // R5
  endtask

  task automatic testLoadIgnored();
    loadBuf(16'h0300); drain(16'h0300, 1'b0, 1'b1);   // R2 during drain
    drain('0, 1'b0, 1'b0);                            // R2 buffer not reloaded
    loadBuf(16'h0005);
    @(negedge clk);
    loadEn = 1'b1; matchIn = 16'h00F0;                // R2 load with start
    drain(16'h0005, 1'b0, 1'b0);
  endtask

  task automatic testEdges();
    loadBuf(16'h0000); drain('0, 1'b0, 1'b0);         // R8
    loadBuf(16'h8000); drain(16'h8000, 1'b0, 1'b0);   // R9 top index
    loadBuf(16'hFFFF); drain(16'hFFFF, 1'b0, 1'b0);   // R9 full buffer
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testBasic();
    testStall();
    testLoadIgnored();
    testEdges();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule